// File: doc/BRIEF.md
# Manager-Interleaved Thread Slot Scheduler

This block decides which instruction thread of a multi-thread DMA engine may issue in the current clock cycle. The engine runs one manager thread and a parameterised number of channel threads (eight by default). Each thread reports whether it is active and whether it is stalled. The scheduler returns at most one grant per cycle. The grant is given as a one-hot vector, as a manager/channel flag with a channel index, and with a valid bit.

Cycles alternate strictly between two kinds of slot. In a manager slot, only the manager thread can be granted. In a channel slot, only a channel can be granted, and the channel is chosen round-robin among those that are active and not stalled. If nobody can use a slot, that slot goes unused. The alternation still moves on, so the manager always keeps every other cycle. The grant is combinational on the current inputs and state. The slot phase and the round-robin pointer update on each rising clock edge.

Top module: `thread_slot_sched`

## Requirements
- R1: At most one thread is granted per cycle. `grant_vec` bit 0 is the manager and bit k+1 is channel k. `grant_valid` is high exactly when a bit of `grant_vec` is set. `grant_chan` holds the granted channel index during a channel grant and 0 otherwise.
- R2: The first cycle after reset is a manager slot. Slots then alternate manager, channel, manager, and so on, on every cycle, whether or not a grant occurred.
- R3: In a manager slot, the manager is granted (`grant_is_mgr`=1, `grant_vec`=1) when it is active and not stalled. Otherwise there is no grant. No channel is ever granted in a manager slot.
- R4: In a channel slot, the granted channel is the first eligible one (active and not stalled) found when searching upward from the round-robin pointer with wrap-around. The manager is never granted in a channel slot.
- R5: After a channel grant to channel k, the pointer becomes k+1, wrapping from N-1 to 0.
- R6: A channel slot with no eligible channel gives no grant and leaves the pointer unchanged.
- R7: Stalled channels are skipped without losing their turn. When all channels stay eligible, every channel is granted exactly once in each N consecutive channel slots.
- R8: A synchronous active-high reset sets the slot to manager and the pointer to channel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mgr_active | input | 1 | Manager thread is running |
| mgr_stalled | input | 1 | Manager thread cannot issue this cycle |
| chan_active | input | N_CHAN | Per-channel running flags |
| chan_stalled | input | N_CHAN | Per-channel stall flags |
| grant_valid | output | 1 | A thread is granted this cycle |
| grant_is_mgr | output | 1 | The grant goes to the manager |
| grant_chan | output | $clog2(N_CHAN) | Index of the granted channel |
| grant_vec | output | N_CHAN+1 | One-hot grant, bit 0 manager |

## Verification
Every grant output is due in the same cycle as the inputs that produce it. The bench therefore drives the inputs just after a falling edge and samples the outputs 1 ns later, before the next rising edge. The slot phase and the pointer change only at the rising edge, so their effect shows in the grant of the following cycle. The bench's own model updates its phase and pointer once per step to match. A reset applied during a step takes effect in the next step, which must be a manager slot with the pointer at channel 0.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic {
        SLOT_MGR  = 1'b0,
        SLOT_CHAN = 1'b1
    } slot_e;

    function automatic slot_e other_slot(input slot_e s);
        return (s == SLOT_MGR) ? SLOT_CHAN : SLOT_MGR;
    endfunction

endpackage

// File: rtl/slot_phase.sv
module slot_phase
    import sched_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_e phase
);

    slot_e phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= SLOT_MGR;
        else     phase_q <= other_slot(phase_q);
    end

    assign phase = phase_q;

endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
    parameter int unsigned N  = 8,
    localparam int unsigned CW = $clog2(N)
) (
    input  logic [N-1:0]  elig,
    input  logic [CW-1:0] ptr,
    output logic          hit,
    output logic [CW-1:0] idx
);

    logic [CW-1:0] cand [N];
    logic [N-1:0]  rot;

    // Candidate at each offset from the pointer, with wrap-around.
    for (genvar g = 0; g < N; g++) begin : g_rot
        logic [CW:0] sum;
        assign sum     = {1'b0, ptr} + (CW+1)'(g);
        assign cand[g] = (sum >= (CW+1)'(N)) ? CW'(sum - (CW+1)'(N)) : sum[CW-1:0];
        assign rot[g]  = elig[cand[g]];
    end

    // Lowest offset wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int o = N - 1; o >= 0; o--) begin
            if (rot[o]) begin
                hit = 1'b1;
                idx = cand[o];
            end
        end
    end

endmodule

// File: rtl/rr_pointer.sv
module rr_pointer #(
    parameter int unsigned N  = 8,
    localparam int unsigned CW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [CW-1:0] last,
    output logic [CW-1:0] ptr
);

    localparam logic [CW-1:0] TOP = CW'(N - 1);

    logic [CW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst)      ptr_q <= '0;
        else if (adv) ptr_q <= (last == TOP) ? '0 : last + 1'b1;
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/thread_slot_sched.sv
module thread_slot_sched
    import sched_pkg::*;
#(
    parameter int unsigned N_CHAN = 8,
    localparam int unsigned CW = $clog2(N_CHAN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mgr_active,
    input  logic              mgr_stalled,
    input  logic [N_CHAN-1:0] chan_active,
    input  logic [N_CHAN-1:0] chan_stalled,
    output logic              grant_valid,
    output logic              grant_is_mgr,
    output logic [CW-1:0]     grant_chan,
    output logic [N_CHAN:0]   grant_vec
);

    slot_e             phase_q;
    logic [CW-1:0]     rr_ptr;
    logic [N_CHAN-1:0] elig;
    logic              pick_hit;
    logic [CW-1:0]     pick_idx;
    logic              mgr_ok;
    logic              chan_gnt;

    slot_phase u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase_q)
    );

    assign elig = chan_active & ~chan_stalled;

    rr_picker #(.N(N_CHAN)) u_pick (
        .elig (elig),
        .ptr  (rr_ptr),
        .hit  (pick_hit),
        .idx  (pick_idx)
    );

    assign mgr_ok   = (phase_q == SLOT_MGR)  && mgr_active && !mgr_stalled;
    assign chan_gnt = (phase_q == SLOT_CHAN) && pick_hit;

    rr_pointer #(.N(N_CHAN)) u_ptr (
        .clk  (clk),
        .rst  (rst),
        .adv  (chan_gnt),
        .last (pick_idx),
        .ptr  (rr_ptr)
    );

    assign grant_valid  = mgr_ok | chan_gnt;
    assign grant_is_mgr = mgr_ok;
    assign grant_chan   = chan_gnt ? pick_idx : '0;

    assign grant_vec[0] = mgr_ok;
    for (genvar c = 0; c < N_CHAN; c++) begin : g_vec
        assign grant_vec[c+1] = chan_gnt && (pick_idx == CW'(c));
    end

endmodule

module thread_slot_sched_chk
    import sched_pkg::*;
#(
    parameter int unsigned N_CHAN = 8,
    localparam int unsigned CW = $clog2(N_CHAN)
) (
    input logic              clk,
    input logic              rst,
    input logic              mgr_active,
    input logic              mgr_stalled,
    input logic [N_CHAN-1:0] chan_active,
    input logic [N_CHAN-1:0] chan_stalled,
    input logic              grant_valid,
    input logic              grant_is_mgr,
    input logic [CW-1:0]     grant_chan,
    input logic [N_CHAN:0]   grant_vec,
    input slot_e             phase_q,
    input logic [CW-1:0]     rr_ptr
);

    logic chan_g;
    assign chan_g = grant_valid && !grant_is_mgr;

    // R1
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_vec) && (grant_valid == (grant_vec != '0)));

    // R2
    mgr_alt_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && grant_is_mgr) |=> !(grant_valid && grant_is_mgr));

    // R2
    chan_alt_chk: assert property (@(posedge clk) disable iff (rst)
        chan_g |=> !chan_g);

    // R3
    mgr_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == SLOT_MGR && (mgr_stalled || !mgr_active)) |-> !grant_valid);

    // R4
    chan_elig_chk: assert property (@(posedge clk) disable iff (rst)
        chan_g |-> (chan_active[grant_chan] && !chan_stalled[grant_chan]));

    // R5
    ptr_adv_chk: assert property (@(posedge clk) disable iff (rst)
        chan_g |=> (rr_ptr == (($past(grant_chan) == CW'(N_CHAN - 1)) ? '0 : $past(grant_chan) + 1'b1)));

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == SLOT_CHAN && !grant_valid) |=> $stable(rr_ptr));

    // R8
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (phase_q == SLOT_MGR && rr_ptr == '0));

endmodule

bind thread_slot_sched thread_slot_sched_chk #(.N_CHAN(N_CHAN)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .mgr_active   (mgr_active),
    .mgr_stalled  (mgr_stalled),
    .chan_active  (chan_active),
    .chan_stalled (chan_stalled),
    .grant_valid  (grant_valid),
    .grant_is_mgr (grant_is_mgr),
    .grant_chan   (grant_chan),
    .grant_vec    (grant_vec),
    .phase_q      (phase_q),
    .rr_ptr       (rr_ptr)
);

// File: tb/thread_slot_sched_tb_top.sv
module thread_slot_sched_tb_top;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mgr_active = 1'b0, mgr_stalled = 1'b0;
    logic [N-1:0] chan_active = '0, chan_stalled = '0;
    logic         grant_valid, grant_is_mgr;
    logic [2:0]   grant_chan;
    logic [N:0]   grant_vec;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Bench model: 0 = manager slot, 1 = channel slot.
    int m_phase = 0;
    int m_ptr   = 0;

    always #2 clk = ~clk;

    thread_slot_sched #(.N_CHAN(N)) dut_i (
        .clk, .rst, .mgr_active, .mgr_stalled, .chan_active, .chan_stalled,
        .grant_valid, .grant_is_mgr, .grant_chan, .grant_vec
    );

    typedef struct packed {
        logic         ma;
        logic         ms;
        logic [N-1:0] act;
        logic [N-1:0] stl;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VT [NV] = '{
        '{1'b1, 1'b0, 8'hFF, 8'h00},
        '{1'b1, 1'b0, 8'hFF, 8'h00},
        '{1'b1, 1'b1, 8'hFF, 8'h00},
        '{1'b1, 1'b0, 8'hFF, 8'h02},
        '{1'b0, 1'b0, 8'h81, 8'h00},
        '{1'b0, 1'b0, 8'h81, 8'h00},
        '{1'b1, 1'b0, 8'h81, 8'h01},
        '{1'b1, 1'b0, 8'h81, 8'h01},
        '{1'b1, 1'b0, 8'h00, 8'h00},
        '{1'b1, 1'b0, 8'h00, 8'h00},
        '{1'b1, 1'b0, 8'h3C, 8'h3C},
        '{1'b1, 1'b0, 8'h3C, 8'h3C},
        '{1'b1, 1'b0, 8'h3C, 8'h10},
        '{1'b1, 1'b0, 8'h3C, 8'h10},
        '{1'b0, 1'b1, 8'h55, 8'h00},
        '{1'b0, 1'b1, 8'h55, 8'h00}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply inputs, compare with the model, then advance one clock.
    task automatic step(input logic ma, input logic ms, input logic [N-1:0] a,
                        input logic [N-1:0] s, input logic r);
        logic [N-1:0] el;
        int           exp_vec, exp_chan, hit;
        mgr_active = ma; mgr_stalled = ms; chan_active = a; chan_stalled = s; rst = r;
        #1;
        el = a & ~s;
        exp_vec = 0; exp_chan = 0; hit = 0;
        if (m_phase == 0) begin
            if (ma && !ms) exp_vec = 1;
        end else begin
            for (int o = 0; o < N; o++) begin
                int c;
                c = (m_ptr + o) % N;
                if (!hit && el[c]) begin
                    hit = 1; exp_chan = c; exp_vec = 1 << (c + 1);
                end
            end
        end
        check(grant_vec == (N+1)'(exp_vec), (m_phase == 0) ? "R3" : "R4",
              int'(grant_vec), exp_vec);
        check(grant_valid == (exp_vec != 0) && grant_is_mgr == (exp_vec == 1)
              && grant_chan == 3'(exp_chan), "R1",
              {grant_valid, grant_is_mgr, grant_chan},
              {(exp_vec != 0), (exp_vec == 1), exp_chan[2:0]});
        if (r) begin
            m_phase = 0; m_ptr = 0;
        end else begin
            if (hit) m_ptr = (exp_chan + 1) % N;
            m_phase = 1 - m_phase;
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        int cnt [N];
        logic [15:0] lfsr;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R8: during reset the slot is manager.
        #1;
        check(grant_vec == '0, "R8", int'(grant_vec), 0);
        mgr_active = 1'b1; #1;
        check(grant_vec == 9'h001, "R8", int'(grant_vec), 1);
        @(negedge clk);
        rst = 1'b0;

        // Vector table.
        for (int i = 0; i < NV; i++)
            step(VT[i].ma, VT[i].ms, VT[i].act, VT[i].stl, 1'b0);

        // R2: with nothing eligible the phase still alternates.
        step(1'b0, 1'b0, '0, '0, 1'b0);
        step(1'b0, 1'b0, '0, '0, 1'b0);
        step(1'b1, 1'b0, 8'hFF, '0, 1'b0);
        check(m_phase == 1, "R2", m_phase, 1);
        step(1'b1, 1'b0, 8'hFF, '0, 1'b0);

        // R6: empty channel slot leaves pointer; next pick follows it.
        step(1'b1, 1'b0, 8'hFF, 8'hFF, 1'b0);
        step(1'b1, 1'b0, 8'hFF, 8'hFF, 1'b0);
        step(1'b1, 1'b0, 8'hFF, 8'h00, 1'b0);
        step(1'b1, 1'b0, 8'hFF, 8'h00, 1'b0);

        // R5: wrap from channel 7 to channel 0.
        while (m_ptr != 7 || m_phase != 0) step(1'b1, 1'b0, 8'hFF, 8'h00, 1'b0);
        step(1'b1, 1'b0, 8'hFF, 8'h00, 1'b0);
        step(1'b1, 1'b0, 8'hFF, 8'h00, 1'b0);
        step(1'b0, 1'b0, 8'hFF, 8'h00, 1'b0);
        check(grant_chan == 3'd0 || m_phase == 0, "R5", grant_chan, 0);
        step(1'b0, 1'b0, 8'hFF, 8'h00, 1'b0);

        // R7: fairness over N channel slots, all eligible.
        for (int c = 0; c < N; c++) cnt[c] = 0;
        for (int k = 0; k < 2 * N; k++) begin
            if (grant_valid && !grant_is_mgr) cnt[grant_chan]++;
            #0;
            step(1'b1, 1'b0, 8'hFF, 8'h00, 1'b0);
        end
        for (int c = 0; c < N; c++) check(cnt[c] == 1, "R7", cnt[c], 1);

        // R7: random activity and stalls against the model.
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[1] & lfsr[2], lfsr[15:8], lfsr[7:0] & lfsr[11:4], 1'b0);
        end

        // R8: reset in the middle of a run.
        while (m_ptr == 0 || m_phase != 1) step(1'b1, 1'b0, 8'hFF, 8'h00, 1'b0);
        step(1'b1, 1'b0, 8'hFF, 8'h00, 1'b1);
        step(1'b1, 1'b0, 8'hFF, 8'h00, 1'b0);
        step(1'b1, 1'b0, 8'hFF, 8'h00, 1'b0);
        check(m_ptr == 1, "R8", m_ptr, 1);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule